// File: doc/BRIEF.md
# Chunked I2C Transfer Sequencer

This block drives a byte-level I2C master engine whose data buffer holds four bytes. A single start strobe hands it one message: target address, 10-bit address flag, direction, byte length and a flag that says whether another message to the same target follows. The block checks the request and prepares the bus. It then splits the message into commands of at most four bytes. Write bytes are moved from a source stream into the engine buffer before each command is issued. Read bytes are moved from the buffer to an output stream once the engine reports that the chunk is complete.

Each command carries its byte count minus one, a chain flag on every non-final chunk so that no STOP is sent, and a repeated-start flag on the final chunk when another message follows. The block also supplies the address bytes in the form the engine expects for 7-bit and 10-bit targets. It watches for engine errors, short chunks and engine silence. It requests buffer flushes, error clears, aborts and soft resets as needed, and it ends every request with a one-cycle done pulse and a status code.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of N bytes is issued as (N+3)/4 commands. Every command except the last carries 4 bytes, and the last carries the rest.
- R2: `cmd_cnt` equals the chunk byte count minus one, so 4 bytes encode as 3 and 1 byte as 0. Each command lasts a single cycle of `cmd_valid`.
- R3: `cmd_chain` is 1 on every command except the last of the message, and 0 on the last.
- R4: `cmd_rpt` is 1 only on the last command, and only when `more` was set with the request. A last command with both flags 0 ends with STOP.
- R5: For a write, exactly as many `buf_wr_en` pulses as the chunk byte count occur before each command. For a read, there are no loads, and the chunk's bytes appear on `out_valid`/`out_data` in buffer order only after that chunk's `chunk_done`.
- R6: For a 7-bit target, `addr_lo` is the address shifted left by one, `addr_hi` is 0x00 and `cmd_ten` is 0.
- R7: For a 10-bit target, `addr_lo` is address bits 7:0. `addr_hi` is 0xF0 with address bits 9:8 placed at bits 2:1, and `cmd_ten` is 1.
- R8: A request is rejected with status 1 and no command if the address exceeds 0x3FF, if it exceeds 0x7F without `ten`, or if the length is 0.
- R9: If `chunk_xfer` differs from the chunk byte count, the result is status 2. `abort` is pulsed if that chunk was not the last or if `more` is set.
- R10: When `chunk_err` is reported, `err_clr` and `flush` are pulsed and the result is status 2. `soft_rst` is pulsed as well if `bus_idle` is low after the clear.
- R11: At start, a low `bus_idle` causes a `soft_rst` pulse. If the bus is still busy in the next cycle, the request fails with status 4 and no command. A bus that is idle at start gets a `flush` pulse before the first chunk.
- R12: If no `chunk_done` arrives within TMO_CYCLES cycles of a command, `abort` is pulsed and the result is status 3. A fully successful request ends with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| addr | input | 11 | Target address (upper bit allows out-of-range requests) |
| ten | input | 1 | 10-bit address mode |
| rd | input | 1 | 1 = read, 0 = write |
| len | input | LEN_W | Message length in bytes |
| more | input | 1 | Another message follows this one |
| bus_idle | input | 1 | Engine reports the bus as idle |
| src_data | input | 8 | Write byte stream head |
| src_pop | output | 1 | Write byte consumed |
| buf_wr_en | output | 1 | Load one byte into the engine buffer |
| buf_wr_data | output | 8 | Byte loaded into the engine buffer |
| buf_rd_en | output | 1 | Take one byte from the engine buffer |
| buf_rd_data | input | 8 | Engine buffer head byte |
| out_valid | output | 1 | Read byte valid |
| out_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Chunk command strobe |
| cmd_cnt | output | 2 | Chunk byte count minus one |
| cmd_chain | output | 1 | Continue without STOP |
| cmd_rpt | output | 1 | End with repeated start |
| cmd_rd | output | 1 | Chunk direction |
| cmd_ten | output | 1 | 10-bit address mode |
| addr_lo | output | 8 | Low address byte |
| addr_hi | output | 8 | High address byte |
| chunk_done | input | 1 | Engine finished the current chunk |
| chunk_xfer | input | 3 | Bytes actually moved by the engine |
| chunk_err | input | 1 | Engine reports an error |
| flush | output | 1 | Flush the engine buffer |
| err_clr | output | 1 | Clear engine error and pending flags |
| soft_rst | output | 1 | Soft reset request |
| abort | output | 1 | Abort the current transfer |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 3 | 0 ok, 1 invalid, 2 remote error, 3 timeout, 4 bus busy |

## Verification
An invalid request shows `done` in the cycle after the edge that samples `start`. An idle start shows `flush` in that same cycle, and a busy start shows `soft_rst` there instead. `cmd_valid` follows in the cycle after the last `buf_wr_en`. A `chunk_done` held across one edge is acted on at that edge: read bytes, the next load, an `abort`, the `err_clr`/`flush` pair or `done` appear in the following cycle, and `done` comes one cycle after an `abort`. The bench drives every input on falling edges. It models the engine's response two falling edges after each command, and it samples and counts every output strobe on falling edges, so each result is read in the cycle the register chain makes it visible.

// File: rtl/i2c_chunk_seq.sv
`timescale 1ns/1ps
module i2c_chunk_seq #(
  parameter int LEN_W      = 8,
  parameter int TMO_CYCLES = 32,
  localparam int TW        = $clog2(TMO_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [10:0]      addr,
  input  logic             ten,
  input  logic             rd,
  input  logic [LEN_W-1:0] len,
  input  logic             more,
  input  logic             bus_idle,
  input  logic [7:0]       src_data,
  output logic             src_pop,
  output logic             buf_wr_en,
  output logic [7:0]       buf_wr_data,
  output logic             buf_rd_en,
  input  logic [7:0]       buf_rd_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             cmd_valid,
  output logic [1:0]       cmd_cnt,
  output logic             cmd_chain,
  output logic             cmd_rpt,
  output logic             cmd_rd,
  output logic             cmd_ten,
  output logic [7:0]       addr_lo,
  output logic [7:0]       addr_hi,
  input  logic             chunk_done,
  input  logic [2:0]       chunk_xfer,
  input  logic             chunk_err,
  output logic             flush,
  output logic             err_clr,
  output logic             soft_rst,
  output logic             abort,
  output logic             done,
  output logic [2:0]       status
);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_RCHK, S_FLUSH, S_LOAD, S_CMD, S_WAIT,
    S_UNLD, S_ECLR, S_ECHK, S_ABORT, S_DONE
  } state_t;

  localparam logic [2:0] ST_OK = 3'd0, ST_INV = 3'd1, ST_REM = 3'd2,
                         ST_TMO = 3'd3, ST_BUSY = 3'd4;

  state_t           state;
  logic [9:0]       a_q;
  logic             ten_q, rd_q, more_q;
  logic [LEN_W-1:0] rem;
  logic [1:0]       bidx;
  logic [TW-1:0]    tmr;
  logic [2:0]       st;

  logic       last;
  logic [2:0] cnt;
  logic       bad_req, idx_end;
  state_t     chunk_start;

  assign last        = rem <= LEN_W'(4);
  assign cnt         = last ? rem[2:0] : 3'd4;
  assign idx_end     = {1'b0, bidx} == cnt - 3'd1;
  assign chunk_start = rd_q ? S_CMD : S_LOAD;
  assign bad_req     = addr[10] | (!ten && (|addr[9:7])) | (len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      a_q <= '0; ten_q <= 1'b0; rd_q <= 1'b0; more_q <= 1'b0;
      rem <= '0; bidx <= '0; tmr <= '0; st <= ST_OK;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          a_q <= addr[9:0]; ten_q <= ten; rd_q <= rd; more_q <= more;
          rem <= len; bidx <= '0;
          if (bad_req) begin
            st <= ST_INV; state <= S_DONE;
          end else state <= bus_idle ? S_FLUSH : S_RST;
        end
        S_RST:   state <= S_RCHK;
        S_RCHK:  if (!bus_idle) begin
          st <= ST_BUSY; state <= S_DONE;
        end else state <= chunk_start;
        S_FLUSH: state <= chunk_start;
        S_LOAD: begin
          bidx <= bidx + 2'd1;
          if (idx_end) begin
            bidx <= '0; state <= S_CMD;
          end
        end
        S_CMD: begin
          tmr <= '0; state <= S_WAIT;
        end
        S_WAIT: if (chunk_done) begin
          if (chunk_err) begin
            st <= ST_REM; state <= S_ECLR;
          end else if (chunk_xfer != cnt) begin
            st <= ST_REM;
            state <= (!last || more_q) ? S_ABORT : S_DONE;
          end else if (rd_q) state <= S_UNLD;
          else if (last) begin
            st <= ST_OK; state <= S_DONE;
          end else begin
            rem <= rem - LEN_W'(4); state <= S_LOAD;
          end
        end else if (tmr == TW'(TMO_CYCLES - 1)) begin
          st <= ST_TMO; state <= S_ABORT;
        end else tmr <= tmr + 1'b1;
        S_UNLD: begin
          bidx <= bidx + 2'd1;
          if (idx_end) begin
            bidx <= '0;
            if (last) begin
              st <= ST_OK; state <= S_DONE;
            end else begin
              rem <= rem - LEN_W'(4); state <= S_CMD;
            end
          end
        end
        S_ECLR:  state <= S_ECHK;
        S_ECHK:  state <= S_DONE;
        S_ABORT: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign src_pop     = state == S_LOAD;
  assign buf_wr_en   = state == S_LOAD;
  assign buf_wr_data = src_data;
  assign buf_rd_en   = state == S_UNLD;
  assign out_valid   = state == S_UNLD;
  assign out_data    = buf_rd_data;

  assign cmd_valid = state == S_CMD;
  assign cmd_cnt   = 2'(cnt - 3'd1);
  assign cmd_chain = !last;
  assign cmd_rpt   = last && more_q;
  assign cmd_rd    = rd_q;
  assign cmd_ten   = ten_q;
  assign addr_lo   = ten_q ? a_q[7:0] : {a_q[6:0], 1'b0};
  assign addr_hi   = ten_q ? {4'hF, 1'b0, a_q[9:8], 1'b0} : 8'h00;

  assign flush    = (state == S_FLUSH) || (state == S_ECLR);
  assign err_clr  = state == S_ECLR;
  assign soft_rst = (state == S_RST) || (state == S_ECHK && !bus_idle);
  assign abort    = state == S_ABORT;
  assign done     = state == S_DONE;
  assign status   = st;

  assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_load_then_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_wr_en) |-> cmd_valid);
  assert_unload_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(chunk_done));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_abort_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (status == ST_REM || status == ST_TMO));
  assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> done);

endmodule

// File: tb/tb_i2c_chunk_seq.sv
`timescale 1ns/1ps
module tb_i2c_chunk_seq;
  localparam int TMO = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ten = 0, rd = 0, more = 0, bus_idle = 1;
  logic [10:0] addr = '0;
  logic [7:0] len = '0;
  logic [7:0] src_data, buf_rd_data, buf_wr_data, out_data, addr_lo, addr_hi;
  logic src_pop, buf_wr_en, buf_rd_en, out_valid, cmd_valid, cmd_chain, cmd_rpt;
  logic cmd_rd, cmd_ten, flush, err_clr, soft_rst, abort, done;
  logic [1:0] cmd_cnt;
  logic [2:0] status;
  logic chunk_done = 0, chunk_err = 0;
  logic [2:0] chunk_xfer = '0;
  int wr_idx = 0, rd_idx = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (src_pop) wr_idx <= wr_idx + 1;
    if (buf_rd_en) rd_idx <= rd_idx + 1;
  end
  assign src_data    = 8'(8'hA0 + wr_idx);
  assign buf_rd_data = 8'(8'h50 + rd_idx);

  i2c_chunk_seq #(.LEN_W(8), .TMO_CYCLES(TMO)) dut (
    .clk, .rst_n, .start, .addr, .ten, .rd, .len, .more, .bus_idle,
    .src_data, .src_pop, .buf_wr_en, .buf_wr_data, .buf_rd_en, .buf_rd_data,
    .out_valid, .out_data, .cmd_valid, .cmd_cnt, .cmd_chain, .cmd_rpt,
    .cmd_rd, .cmd_ten, .addr_lo, .addr_hi, .chunk_done, .chunk_xfer,
    .chunk_err, .flush, .err_clr, .soft_rst, .abort, .done, .status);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  int ncmd, nrd, rd_bad, n_abort, n_srst, n_clr, n_flush, st_s, got_done, wr_total;
  int cnt_a[16], chain_a[16], rpt_a[16], wrb_a[16];
  logic [7:0] lo_s, hi_s;
  logic ten_s;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [10:0] a, input logic t, input logic r, input int n,
                     input logic m, input int short_at, input int err_at,
                     input int hang_at, input int bmode);
    int resp, lastc, wrc, exp_rd;
    resp = 0; lastc = 0; wrc = 0; exp_rd = rd_idx;
    ncmd = 0; nrd = 0; rd_bad = 0; n_abort = 0; n_srst = 0; n_clr = 0;
    n_flush = 0; st_s = -1; got_done = 0; wr_total = 0;
    bus_idle = (bmode == 1 || bmode == 2) ? 1'b0 : 1'b1;
    addr = a; ten = t; rd = r; len = 8'(n); more = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      chunk_done = 1'b0; chunk_err = 1'b0;
      if (resp > 0) begin
        resp--;
        if (resp == 0) begin
          chunk_done = 1'b1;
          chunk_err = (err_at == ncmd - 1);
          chunk_xfer = 3'((short_at == ncmd - 1) ? lastc - 1 : lastc);
          if (chunk_err && bmode == 3) bus_idle = 1'b0;
        end
      end
      if (cmd_valid) begin
        cnt_a[ncmd] = cmd_cnt; chain_a[ncmd] = cmd_chain; rpt_a[ncmd] = cmd_rpt;
        wrb_a[ncmd] = wrc; wrc = 0;
        lo_s = addr_lo; hi_s = addr_hi; ten_s = cmd_ten;
        lastc = cmd_cnt + 1;
        resp = (hang_at == ncmd) ? 0 : 2;
        ncmd++;
      end
      if (buf_wr_en) begin wrc++; wr_total++; end
      if (out_valid) begin
        nrd++;
        if (out_data != 8'(8'h50 + exp_rd)) rd_bad++;
        exp_rd++;
      end
      if (flush) n_flush++;
      if (err_clr) n_clr++;
      if (abort) n_abort++;
      if (soft_rst) begin
        n_srst++;
        if (bmode == 1) bus_idle = 1'b1;
      end
      if (done) begin
        st_s = status; got_done = 1;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chunk_done = 1'b0; chunk_err = 1'b0; bus_idle = 1'b1;
  endtask

  task automatic t_reset;
    chk("R12", "reset done", done, 0);
    chk("R2", "reset cmd_valid", cmd_valid, 0);
    chk("R12", "reset status", status, 0);
    chk("R5", "reset buf_wr_en", buf_wr_en, 0);
    chk("R11", "reset soft_rst", soft_rst, 0);
  endtask

  task automatic t_write_chain;
    run(11'h05A, 0, 0, 10, 0, -1, -1, -1, 0);
    chk("R12", "wr10 status", st_s, 0);
    chk("R1", "wr10 commands", ncmd, 3);
    chk("R2", "wr10 cnt0", cnt_a[0], 3);
    chk("R2", "wr10 cnt1", cnt_a[1], 3);
    chk("R2", "wr10 cnt2", cnt_a[2], 1);
    chk("R3", "wr10 chain0", chain_a[0], 1);
    chk("R3", "wr10 chain1", chain_a[1], 1);
    chk("R3", "wr10 chain2", chain_a[2], 0);
    chk("R4", "wr10 rpt last", rpt_a[2], 0);
    chk("R5", "wr10 loads0", wrb_a[0], 4);
    chk("R5", "wr10 loads2", wrb_a[2], 2);
    chk("R6", "wr10 addr_lo", lo_s, 8'hB4);
    chk("R6", "wr10 addr_hi", hi_s, 8'h00);
    chk("R6", "wr10 ten", ten_s, 0);
    chk("R11", "wr10 start flush", n_flush, 1);
    chk("R9", "wr10 no abort", n_abort, 0);
    run(11'h07F, 0, 0, 4, 1, -1, -1, -1, 0);
    chk("R1", "wr4 commands", ncmd, 1);
    chk("R3", "wr4 chain", chain_a[0], 0);
    chk("R4", "wr4 rpt", rpt_a[0], 1);
    chk("R8", "addr 0x7F accepted", st_s, 0);
  endtask

  task automatic t_read_ten;
    run(11'h2C7, 1, 1, 5, 1, -1, -1, -1, 0);
    chk("R12", "rd5 status", st_s, 0);
    chk("R1", "rd5 commands", ncmd, 2);
    chk("R2", "rd5 cnt1", cnt_a[1], 0);
    chk("R3", "rd5 chain0", chain_a[0], 1);
    chk("R4", "rd5 rpt0", rpt_a[0], 0);
    chk("R4", "rd5 rpt1", rpt_a[1], 1);
    chk("R5", "rd5 loads", wr_total, 0);
    chk("R5", "rd5 bytes", nrd, 5);
    chk("R5", "rd5 order", rd_bad, 0);
    chk("R7", "rd5 addr_lo", lo_s, 8'hC7);
    chk("R7", "rd5 addr_hi", hi_s, 8'hF4);
    chk("R7", "rd5 ten", ten_s, 1);
    run(11'h3FF, 1, 1, 1, 0, -1, -1, -1, 0);
    chk("R8", "addr 0x3FF accepted", st_s, 0);
    chk("R7", "rd1 addr_hi", hi_s, 8'hF6);
  endtask

  task automatic t_invalid;
    run(11'h080, 0, 0, 3, 0, -1, -1, -1, 0);
    chk("R8", "7-bit 0x80 status", st_s, 1);
    chk("R8", "7-bit 0x80 commands", ncmd, 0);
    run(11'h400, 1, 0, 3, 0, -1, -1, -1, 0);
    chk("R8", "0x400 status", st_s, 1);
    chk("R8", "0x400 commands", ncmd, 0);
    run(11'h010, 0, 0, 0, 0, -1, -1, -1, 0);
    chk("R8", "len0 status", st_s, 1);
    chk("R8", "len0 flush", n_flush, 0);
  endtask

  task automatic t_short;
    run(11'h021, 0, 0, 6, 0, 1, -1, -1, 0);
    chk("R9", "short last status", st_s, 2);
    chk("R9", "short last abort", n_abort, 0);
    run(11'h021, 0, 0, 6, 0, 0, -1, -1, 0);
    chk("R9", "short first status", st_s, 2);
    chk("R9", "short first abort", n_abort, 1);
    chk("R9", "short first commands", ncmd, 1);
    run(11'h021, 0, 1, 3, 1, 0, -1, -1, 0);
    chk("R9", "short combined abort", n_abort, 1);
    chk("R9", "short read no bytes", nrd, 0);
  endtask

  task automatic t_err;
    run(11'h033, 0, 0, 4, 0, -1, 0, -1, 3);
    chk("R10", "err status", st_s, 2);
    chk("R10", "err clear", n_clr, 1);
    chk("R10", "err flushes", n_flush, 2);
    chk("R10", "err stuck reset", n_srst, 1);
    run(11'h033, 0, 0, 4, 0, -1, 0, -1, 0);
    chk("R10", "err idle reset", n_srst, 0);
    chk("R10", "err idle status", st_s, 2);
  endtask

  task automatic t_busy;
    run(11'h044, 0, 0, 2, 0, -1, -1, -1, 1);
    chk("R11", "recover reset", n_srst, 1);
    chk("R11", "recover flush", n_flush, 0);
    chk("R11", "recover status", st_s, 0);
    chk("R11", "recover commands", ncmd, 1);
    run(11'h044, 0, 0, 2, 0, -1, -1, -1, 2);
    chk("R11", "stuck status", st_s, 4);
    chk("R11", "stuck commands", ncmd, 0);
  endtask

  task automatic t_timeout;
    run(11'h055, 0, 0, 3, 0, -1, -1, 0, 0);
    chk("R12", "timeout status", st_s, 3);
    chk("R12", "timeout abort", n_abort, 1);
    chk("R12", "timeout done", got_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_chain();
    t_read_ten();
    t_invalid();
    t_short();
    t_err();
    t_busy();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule